// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block sequences a multi-register block transfer between a register file and word-addressed memory. A single start pulse supplies a register-select mask, a base address and a set of mode flags. The block then walks the selected register indices one at a time. For each one it issues a word request that carries the register index, the byte address and the transfer direction, and it holds that request until the memory side accepts it with a ready handshake.

The walk order follows the direction flag. Ascending mode visits indices from low to high and moves the address upward. Descending mode visits them from high to low and moves it downward. The pre/post flag decides whether the 4-byte step is taken before or after each access. On completion the block pulses a done strobe and presents the final running address, together with a flag that tells the register file whether to write that address back into the base register. A mask that selects the top register index, or a set privileged flag, is refused with a trap and no memory traffic. The register file and the memory sit outside the block.

Top module: `lsm_seq`

## Requirements
- R1: With the direction flag `up_i`=1, requests visit the selected indices in strictly ascending order, and each accepted request moves the running address up by 4.
- R2: With `up_i`=0, requests visit the selected indices in strictly descending order, and each accepted request moves the running address down by 4, wrapping modulo 2^32.
- R3: With `pre_i`=1 the k-th request (k from 0) carries base ± 4·(k+1). With `pre_i`=0 it carries base ± 4·k.
- R4: In the done cycle `final_addr_o` equals base ± 4·n for n selected registers, and `wb_o` is 1 exactly when `wb_i` was 1 and the operation was not trapped.
- R5: A mask with bit 15 (the top index) set produces `done_o`=1 and `trap_o`=1 one cycle after start, with no request ever issued.
- R6: A start with `priv_i`=1 traps in the same way as R5, whatever the mask, and issues no request.
- R7: `req_we_o` is 1 (write to memory) when `load_i` was 0, and 0 (read into the register) when `load_i` was 1, for every request of the operation.
- R8: An all-zero mask completes with `done_o`=1 one cycle after start, with no request, `trap_o`=0 and `final_addr_o` equal to the base.
- R9: `start_i` is ignored unless the block is idle. A start during a transfer or in the done cycle launches no new operation.
- R10: While `req_o`=1 and `ready_i`=0, `req_idx_o`, `req_addr_o` and `req_we_o` hold their values.
- R11: `done_o` is a one-cycle pulse, and `req_o` is 0 in the done cycle.
- R12: After reset `req_o`, `done_o`, `trap_o` and `wb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch an operation (taken only when idle) |
| list_i | input | 16 | Register-select mask, bit i selects register i |
| base_i | input | 32 | Base byte address |
| pre_i | input | 1 | 1: step before each access, 0: after |
| up_i | input | 1 | 1: ascending, 0: descending |
| wb_i | input | 1 | Request write-back of the final address |
| load_i | input | 1 | 1: memory to register, 0: register to memory |
| priv_i | input | 1 | Privileged-transfer flag, always trapped |
| req_o | output | 1 | Memory request valid |
| req_we_o | output | 1 | Request is a write to memory |
| req_idx_o | output | 4 | Register index for the request |
| req_addr_o | output | 32 | Byte address for the request |
| ready_i | input | 1 | Memory accepts the current request |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Completion was an illegal-operation trap |
| final_addr_o | output | 32 | Final running address, valid with done |
| wb_o | output | 1 | Write final address to base, valid with done |

## Verification
Two events can meet in one cycle: the handshake that retires the last request, and a fresh start pulse, which the block must refuse because it is not idle. The bench raises `start_i` with a different mask in exactly the cycle it grants `ready_i` to the final request, and again in the done cycle. It then judges that the completion values still belong to the first operation and that `req_o` stays low for the cycles that follow. Stalled handshakes are mixed in so that the retire cycle does not fall at a fixed offset from the start.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
// Picks the next register index from the remaining mask: lowest set bit when
// walking upward, highest set bit when walking downward.
module lsm_pick #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  mask_i,
   input  logic             up_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   logic [IDX_W-1:0] lo_idx;
   logic [IDX_W-1:0] hi_idx;

   always_comb begin
      lo_idx = '0;
      for (int i = NREG-1; i >= 0; i--)
         if (mask_i[i]) lo_idx = IDX_W'(i);
   end

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < NREG; i++)
         if (mask_i[i]) hi_idx = IDX_W'(i);
   end

   assign idx_o = up_i ? lo_idx : hi_idx;
   assign any_o = |mask_i;
endmodule

// File: rtl/lsm_step.sv
// Address stepper: one word stride up or down.
module lsm_step #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              up_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(STEP);
   assign addr_o = up_i ? (addr_i + STRIDE) : (addr_i - STRIDE);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
   parameter int NREG   = 16,
   parameter int ADDR_W = 32,
   parameter int STEP   = 4,
   parameter int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NREG-1:0]   list_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              pre_i,
   input  logic              up_i,
   input  logic              wb_i,
   input  logic              load_i,
   input  logic              priv_i,
   output logic              req_o,
   output logic              req_we_o,
   output logic [IDX_W-1:0]  req_idx_o,
   output logic [ADDR_W-1:0] req_addr_o,
   input  logic              ready_i,
   output logic              done_o,
   output logic              trap_o,
   output logic [ADDR_W-1:0] final_addr_o,
   output logic              wb_o
);
   import lsm_pkg::*;

   localparam int TOP_IDX = NREG - 1;

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("lsm_seq: NREG must be at least 2");
      end
      if (STEP < 1) begin : g_bad_step
         $error("lsm_seq: STEP must be positive");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("lsm_seq: ADDR_W too small");
      end
   endgenerate

   lsm_state_e        state_q;
   logic [NREG-1:0]   mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic              up_q, pre_q, load_q, wb_q, trap_q;

   logic [IDX_W-1:0]  pick_idx;
   logic              pick_any;
   logic [ADDR_W-1:0] step_addr;
   logic [NREG-1:0]   mask_nx;
   logic              illegal;

   lsm_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
      .mask_i (mask_q),
      .up_i   (up_q),
      .idx_o  (pick_idx),
      .any_o  (pick_any)
   );

   lsm_step #(.ADDR_W(ADDR_W), .STEP(STEP)) u_step (
      .addr_i (addr_q),
      .up_i   (up_q),
      .addr_o (step_addr)
   );

   always_comb begin
      mask_nx = mask_q;
      mask_nx[pick_idx] = 1'b0;
   end

   assign illegal = list_i[TOP_IDX] | priv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         addr_q  <= '0;
         up_q    <= 1'b0;
         pre_q   <= 1'b0;
         load_q  <= 1'b0;
         wb_q    <= 1'b0;
         trap_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  up_q   <= up_i;
                  pre_q  <= pre_i;
                  load_q <= load_i;
                  wb_q   <= wb_i;
                  trap_q <= illegal;
                  addr_q <= base_i;
                  mask_q <= illegal ? '0 : list_i;
                  state_q <= (illegal || list_i == '0) ? ST_DONE : ST_XFER;
               end
            end
            ST_XFER: begin
               if (ready_i && pick_any) begin
                  mask_q <= mask_nx;
                  addr_q <= step_addr;
                  if (mask_nx == '0) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_o        = (state_q == ST_XFER);
   assign req_we_o     = req_o & ~load_q;
   assign req_idx_o    = pick_idx;
   assign req_addr_o   = pre_q ? step_addr : addr_q;
   assign done_o       = (state_q == ST_DONE);
   assign trap_o       = done_o & trap_q;
   assign final_addr_o = addr_q;
   assign wb_o         = done_o & wb_q & ~trap_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int NREG   = 16,
   parameter int ADDR_W = 32,
   parameter int STEP   = 4,
   parameter int IDX_W  = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_o,
   input logic              req_we_o,
   input logic [IDX_W-1:0]  req_idx_o,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic              ready_i,
   input logic              done_o,
   input logic              trap_o,
   input logic              up_q,
   input logic              load_q
);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(STEP);
   localparam logic [IDX_W-1:0]  TOPI   = IDX_W'(NREG-1);

   // R1 / R2: index order follows direction
   p_idx_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ready_i) |=> (!req_o ||
         (up_q ? (req_idx_o > $past(req_idx_o)) : (req_idx_o < $past(req_idx_o)))));

   // R1 / R2: address moves one stride per accepted request
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ready_i) |=> (!req_o ||
         (req_addr_o == (up_q ? $past(req_addr_o) + STRIDE : $past(req_addr_o) - STRIDE))));

   // R5: top index never requested
   p_no_top_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (req_idx_o != TOPI));

   // R6: a trap completion follows no request
   p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (!req_o && !$past(req_o)));

   // R7: direction of every request follows the load flag
   p_we_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (req_we_o == !load_q));

   // R10: request held while stalled
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ready_i) |=> (req_o && $stable(req_idx_o) && $stable(req_addr_o)
                               && $stable(req_we_o)));

   // R11: done is a single-cycle pulse with no request beside it
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_o);
endmodule

bind lsm_seq lsm_seq_chk #(
   .NREG(NREG), .ADDR_W(ADDR_W), .STEP(STEP), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_o      (req_o),
   .req_we_o   (req_we_o),
   .req_idx_o  (req_idx_o),
   .req_addr_o (req_addr_o),
   .ready_i    (ready_i),
   .done_o     (done_o),
   .trap_o     (trap_o),
   .up_q       (up_q),
   .load_q     (load_q)
);

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] list_i = '0;
   logic [31:0] base_i = '0;
   logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0, priv_i = 1'b0;
   logic        req_o, req_we_o;
   logic [3:0]  req_idx_o;
   logic [31:0] req_addr_o;
   logic        ready_i = 1'b0;
   logic        done_o, trap_o, wb_o;
   logic [31:0] final_addr_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #10 clk = ~clk;   // 50 MHz

   lsm_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i), .base_i(base_i),
      .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i), .load_i(load_i), .priv_i(priv_i),
      .req_o(req_o), .req_we_o(req_we_o), .req_idx_o(req_idx_o), .req_addr_o(req_addr_o),
      .ready_i(ready_i), .done_o(done_o), .trap_o(trap_o),
      .final_addr_o(final_addr_o), .wb_o(wb_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // Runs one operation and checks every request and the completion.
   task automatic run_op(input logic [15:0] list, input logic [31:0] base,
                         input bit pre, input bit up, input bit wb, input bit load,
                         input bit priv, input int stall, input bit poke, input string tag);
      int exp_idx[$];
      bit legal;
      int n, k, st, cyc;
      bit got_done;
      logic [31:0] ea, fin;
      legal = !list[15] && !priv;
      if (legal) begin
         if (up) begin
            for (int i = 0; i < 16; i++) if (list[i]) exp_idx.push_back(i);
         end else begin
            for (int i = 15; i >= 0; i--) if (list[i]) exp_idx.push_back(i);
         end
      end
      n = exp_idx.size();
      fin = up ? base + 32'(4*n) : base - 32'(4*n);
      list_i = list; base_i = base; pre_i = pre; up_i = up; wb_i = wb;
      load_i = load; priv_i = priv; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      list_i = 16'h0F0F; base_i = 32'hDEAD0000;   // later input changes must not matter
      k = 0; st = stall; cyc = 0; got_done = 0;
      while (!got_done && cyc < 300) begin
         ready_i = 1'b0;
         if (done_o) begin
            got_done = 1;
            if (n == 0)
               chk(cyc == 0, legal ? "R8" : (priv ? "R6" : "R5"),
                   {tag, " done latency"}, cyc, 0);
            chk(trap_o == !legal, legal ? "R4" : (priv ? "R6" : "R5"),
                {tag, " trap flag"}, trap_o, !legal);
            chk(k == n, legal ? "R4" : "R5", {tag, " request count"}, k, n);
            chk(final_addr_o == fin, n == 0 ? "R8" : "R4", {tag, " final address"},
                final_addr_o, fin);
            chk(wb_o == (wb && legal), "R4", {tag, " writeback flag"}, wb_o, wb && legal);
            chk(!req_o, "R11", {tag, " no request with done"}, req_o, 0);
            if (poke) begin start_i = 1'b1; list_i = 16'h0003; end
         end else if (req_o) begin
            if (k >= n) begin
               chk(0, legal ? "R8" : (priv ? "R6" : "R5"), {tag, " unexpected request"},
                   req_idx_o, 32'hFFFF);
               k++;
            end else begin
               ea = up ? base + 32'(4*(k + (pre ? 1 : 0)))
                       : base - 32'(4*(k + (pre ? 1 : 0)));
               chk(req_idx_o == 4'(exp_idx[k]), st != stall ? "R10" : (up ? "R1" : "R2"),
                   {tag, " request index"}, req_idx_o, exp_idx[k]);
               chk(req_addr_o == ea, st != stall ? "R10" : "R3", {tag, " request address"},
                   req_addr_o, ea);
               chk(req_we_o == !load, "R7", {tag, " write enable"}, req_we_o, !load);
               if (st > 0) st--;
               else begin
                  ready_i = 1'b1;
                  if (poke && k == n-1) begin start_i = 1'b1; list_i = 16'h00F0; end
                  k++;
                  st = stall;
               end
            end
         end
         @(negedge clk);
         ready_i = 1'b0;
         start_i = 1'b0;
         cyc++;
      end
      chk(got_done, "R11", {tag, " done seen"}, got_done, 1);
      chk(!done_o, "R11", {tag, " done one cycle"}, done_o, 0);
      chk(!req_o, "R9", {tag, " idle after done"}, req_o, 0);
      @(negedge clk);
      chk(!req_o && !done_o, "R9", {tag, " still idle"}, {req_o, done_o}, 0);
   endtask

   task automatic t_reset();
      chk(!req_o && !done_o && !trap_o && !wb_o, "R12", "reset outputs",
          {req_o, done_o, trap_o, wb_o}, 0);
   endtask

   task automatic t_up_post_load();   run_op(16'h00A5, 32'h0000_1000, 0, 1, 1, 1, 0, 0, 0, "up/post/load"); endtask
   task automatic t_down_pre_store(); run_op(16'h7103, 32'h0000_2000, 1, 0, 1, 0, 0, 2, 0, "down/pre/store"); endtask
   task automatic t_up_pre_nowb();    run_op(16'h4001, 32'h0000_3000, 1, 1, 0, 0, 0, 1, 0, "up/pre/nowb"); endtask
   task automatic t_down_wrap();      run_op(16'h000E, 32'h0000_0008, 0, 0, 1, 1, 0, 0, 0, "down wrap"); endtask
   task automatic t_empty();          run_op(16'h0000, 32'h0000_5550, 1, 1, 1, 0, 0, 0, 0, "empty list"); endtask
   task automatic t_trap_top();       run_op(16'h8001, 32'h0000_6000, 0, 1, 1, 1, 0, 0, 0, "top index trap"); endtask
   task automatic t_trap_priv();      run_op(16'h0011, 32'h0000_7000, 1, 0, 1, 0, 1, 0, 0, "priv trap"); endtask
   task automatic t_start_collide();  run_op(16'h0030, 32'h0000_8000, 0, 1, 1, 1, 0, 1, 1, "start on last ready"); endtask
   task automatic t_full_up();        run_op(16'h7FFF, 32'hFFFF_FFE0, 1, 1, 1, 1, 0, 0, 0, "fifteen up"); endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_up_post_load();
      t_down_pre_store();
      t_up_pre_nowb();
      t_down_wrap();
      t_empty();
      t_trap_top();
      t_trap_priv();
      t_start_collide();
      t_full_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule